// File: doc/BRIEF.md
# Indexed Indirect Effective Address Unit

This block turns a 24-bit instruction word into the address of its operand. It splits the word into an opcode, a modifier and a 15-bit address field. It adds the index register named by the modifier to the address field. If the modifier's indirect flag is set, it then reads one memory word at that sum and takes the low bits of that word as the final address.

Three 15-bit index registers are loaded through a private write port. Selector value zero names no register and always yields zero, so an instruction that uses it gets absolute addressing. A caller pulses `start` with a word on `instr`. A direct reference returns `ea` together with a one-cycle `done` on the next clock edge. An indirect reference first puts one read on a synchronous memory port, which returns data one cycle later, and so finishes one cycle after a direct one would.

Top module: `ea_unit`

## Requirements
- R1: After reset, `done` is 0, `ea` is 0, `opcode` is 0, `mem_re` is 0, and every index register holds 0.
- R2: The instruction fields are opcode = bits 23:18, indirect flag = bit 17, index selector = bits 16:15, and address field = bits 14:0. `opcode` shows the opcode of the reference that most recently completed.
- R3: Selector value 0 adds zero, so the indexed address equals the address field.
- R4: For selectors 1 to 3, the indexed address is the address field plus that index register, modulo 2^15.
- R5: With the indirect flag at 0, an accepted start produces `done`=1 on the next clock edge, with `ea` equal to the indexed address, and `mem_re` stays 0.
- R6: With the indirect flag at 1, `mem_re` is 1 in the cycle of the accepted start and `mem_addr` equals the indexed address. Two clock edges later, `done`=1 and `ea` equals bits 14:0 of the word the memory returned.
- R7: A write to index selector 0 has no effect. Later references that use selector 0 still add zero.
- R8: `done` is high for exactly one cycle per completed reference, so back-to-back direct starts complete on consecutive cycles. `ea` keeps its value until the next reference completes.
- R9: A start that arrives while an indirect read is outstanding is ignored. It issues no read and produces no completion.
- R10: An index write in the same cycle as a start does not change that start's sum. The new value is used by later starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a reference for `instr` |
| instr | input | 24 | Instruction word |
| idx_we | input | 1 | Index register write enable |
| idx_sel | input | 2 | Index register to write |
| idx_wdata | input | 15 | Value to write |
| mem_re | output | 1 | Memory read request |
| mem_addr | output | 15 | Memory read address |
| mem_rdata | input | 24 | Memory read data, valid the cycle after `mem_re` |
| done | output | 1 | Reference complete, one-cycle pulse |
| ea | output | 15 | Effective address |
| opcode | output | 6 | Opcode of the completed reference |

## Verification
Four behaviours are checked by assertions on every cycle:
- selector zero passes the address field through unchanged on a direct start;
- an accepted direct start is always followed by `done`;
- every read is followed, two edges later, by `done` carrying the returned low bits;
- no second read or completion comes out of the cycle that follows a read.

Some behaviours can only be shown by the bench's scenarios, which are compared against a behavioural model on every clock:
- wrap-around of the index sum;
- the ignored write to selector 0;
- the ordering of an index write against a start in the same cycle;
- the reset contents of the index registers;
- the opcode that travels with a completion.

// File: rtl/ea_unit.sv
module ea_unit #(
  parameter int ADDR_W = 15,
  parameter int SEL_W  = 2,
  parameter int OP_W   = 6,
  localparam int WORD_W  = OP_W + 1 + SEL_W + ADDR_W,
  localparam int NREG    = 1 << SEL_W,
  localparam int SEL_LSB = ADDR_W,
  localparam int IND_BIT = ADDR_W + SEL_W,
  localparam int OP_LSB  = WORD_W - OP_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [WORD_W-1:0] instr,
  input  logic              idx_we,
  input  logic [SEL_W-1:0]  idx_sel,
  input  logic [ADDR_W-1:0] idx_wdata,
  output logic              mem_re,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic              done,
  output logic [ADDR_W-1:0] ea,
  output logic [OP_W-1:0]   opcode
);

  logic [ADDR_W-1:0] regs [NREG];
  logic [SEL_W-1:0]  sel;
  logic [ADDR_W-1:0] afield, idx_val, sum;
  logic              ind, accept, pend;
  logic [OP_W-1:0]   pend_op;
  logic              unused_hi;

  assign afield  = instr[ADDR_W-1:0];
  assign sel     = instr[SEL_LSB +: SEL_W];
  assign ind     = instr[IND_BIT];
  assign idx_val = (sel == '0) ? '0 : regs[sel];
  assign sum     = afield + idx_val;
  assign accept  = start & ~pend;
  assign mem_re  = accept & ind;
  assign mem_addr = sum;
  assign unused_hi = ^mem_rdata[WORD_W-1:ADDR_W];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else if (idx_we && idx_sel != '0) begin
      regs[idx_sel] <= idx_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend    <= 1'b0;
      pend_op <= '0;
      done    <= 1'b0;
      ea      <= '0;
      opcode  <= '0;
    end else begin
      done <= 1'b0;
      if (pend) begin
        pend   <= 1'b0;
        done   <= 1'b1;
        ea     <= mem_rdata[ADDR_W-1:0];
        opcode <= pend_op;
      end else if (accept) begin
        if (ind) begin
          pend    <= 1'b1;
          pend_op <= instr[OP_LSB +: OP_W];
        end else begin
          done   <= 1'b1;
          ea     <= sum;
          opcode <= instr[OP_LSB +: OP_W];
        end
      end
    end
  end

endmodule

module ea_unit_chk #(
  parameter int ADDR_W = 15,
  parameter int SEL_W  = 2,
  parameter int WORD_W = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic [WORD_W-1:0] instr,
  input logic              pend,
  input logic              mem_re,
  input logic [WORD_W-1:0] mem_rdata,
  input logic              done,
  input logic [ADDR_W-1:0] ea
);
  localparam int IND_BIT = ADDR_W + SEL_W;

  AST_SEL0_ABSOLUTE: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !pend && !instr[IND_BIT] && instr[ADDR_W +: SEL_W] == '0)
      |=> ea == $past(instr[ADDR_W-1:0])); // R3
  AST_DIRECT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !pend && !instr[IND_BIT]) |=> done); // R5
  AST_INDIRECT_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    $past(mem_re) |=> (done && ea == $past(mem_rdata[ADDR_W-1:0]))); // R6
  AST_NO_REISSUE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_re |=> (!mem_re && !done)); // R9
endmodule

bind ea_unit ea_unit_chk #(.ADDR_W(ADDR_W), .SEL_W(SEL_W), .WORD_W(WORD_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .instr(instr), .pend(pend),
  .mem_re(mem_re), .mem_rdata(mem_rdata), .done(done), .ea(ea)
);

// File: tb/tb_ea_unit.sv
`timescale 1ns/1ps
module tb_ea_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [23:0] instr = '0;
  logic        idx_we = 1'b0;
  logic [1:0]  idx_sel = '0;
  logic [14:0] idx_wdata = '0;
  logic        mem_re;
  logic [14:0] mem_addr;
  logic [23:0] mem_rdata = '0;
  logic        done;
  logic [14:0] ea;
  logic [5:0]  opcode;

  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  ea_unit dut (
    .clk(clk), .rst_n(rst_n), .start(start), .instr(instr),
    .idx_we(idx_we), .idx_sel(idx_sel), .idx_wdata(idx_wdata),
    .mem_re(mem_re), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .done(done), .ea(ea), .opcode(opcode)
  );

  function automatic logic [23:0] memf(input logic [14:0] a);
    return 24'(a * 24'd40503 + 24'h5A3C1);
  endfunction

  always @(posedge clk) if (mem_re) mem_rdata <= memf(mem_addr);

  int m_idx [4];
  bit m_pend, m_done;
  int m_pend_addr, m_ea, m_op, m_pend_op;

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic instr_t_dummy(); endfunction

  function automatic int isum(input logic [23:0] w);
    int s = w[16:15];
    return (int'(w[14:0]) + (s == 0 ? 0 : m_idx[s])) % 32768;
  endfunction

  task automatic cyc(input string tag, input bit st, input logic [23:0] w,
                     input bit we = 0, input logic [1:0] ws = 0, input logic [14:0] wd = 0);
    bit acc;
    @(negedge clk);
    start = st; instr = w; idx_we = we; idx_sel = ws; idx_wdata = wd;
    #0.5;
    acc = st && !m_pend;
    chk(tag, "mem_re", int'(mem_re), int'(acc && w[17]));
    if (acc && w[17]) chk(tag, "mem_addr", int'(mem_addr), isum(w));
    @(posedge clk);
    m_done = 0;
    if (m_pend) begin
      m_pend = 0; m_done = 1; m_ea = int'(memf(15'(m_pend_addr)) & 24'h7FFF); m_op = m_pend_op;
    end else if (acc) begin
      if (w[17]) begin m_pend = 1; m_pend_addr = isum(w); m_pend_op = int'(w[23:18]); end
      else begin m_done = 1; m_ea = isum(w); m_op = int'(w[23:18]); end
    end
    if (we && ws != 0) m_idx[ws] = int'(wd);
    #0.5;
    chk(tag, "done", int'(done), int'(m_done));
    chk(tag, "ea", int'(ea), m_ea);
    chk(tag, "opcode", int'(opcode), m_op);
  endtask

  function automatic logic [23:0] mk(input int op, input bit ind, input int sel, input int a);
    return {6'(op), ind, 2'(sel), 15'(a)};
  endfunction

  initial begin
    #150000;
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4; i++) m_idx[i] = 0;
    m_pend = 0; m_done = 0; m_ea = 0; m_op = 0;
    repeat (3) @(posedge clk);
    #0.5;
    chk("R1", "done", int'(done), 0);
    chk("R1", "ea", int'(ea), 0);
    chk("R1", "opcode", int'(opcode), 0);
    chk("R1", "mem_re", int'(mem_re), 0);
    @(negedge clk); rst_n = 1'b1;
    cyc("R1", 1, mk(5, 0, 1, 16'h1234));
    cyc("R1", 1, mk(6, 0, 3, 15'h0042));
    cyc("R1", 0, '0);
    cyc("R4", 0, '0, 1, 1, 15'h0100);
    cyc("R4", 0, '0, 1, 2, 15'h7FFF);
    cyc("R4", 0, '0, 1, 3, 15'h2AAA);
    cyc("R3", 1, mk(1, 0, 0, 15'h5555));
    cyc("R4", 1, mk(2, 0, 1, 15'h0FFF));
    cyc("R4", 1, mk(3, 0, 2, 15'h0001));
    cyc("R4", 1, mk(4, 0, 3, 15'h6000));
    cyc("R2", 1, mk(63, 0, 2, 15'h7FFF));
    cyc("R8", 0, '0);
    cyc("R8", 0, '0);
    cyc("R6", 1, mk(9, 1, 1, 15'h0200));
    cyc("R6", 0, '0);
    cyc("R6", 0, '0);
    cyc("R6", 1, mk(10, 1, 0, 15'h3333));
    cyc("R9", 1, mk(11, 0, 2, 15'h0010));
    cyc("R9", 0, '0);
    cyc("R6", 1, mk(12, 1, 2, 15'h0005));
    cyc("R9", 1, mk(13, 1, 3, 15'h0007));
    cyc("R6", 1, mk(14, 0, 1, 15'h0003));
    cyc("R7", 0, '0, 1, 0, 15'h1111);
    cyc("R7", 1, mk(15, 0, 0, 15'h0777));
    cyc("R7", 1, mk(16, 1, 0, 15'h0123));
    cyc("R7", 0, '0);
    cyc("R10", 1, mk(17, 0, 1, 15'h0020), 1, 1, 15'h4000);
    cyc("R10", 1, mk(18, 0, 1, 15'h0020));
    cyc("R10", 1, mk(19, 1, 3, 15'h0001), 1, 3, 15'h0500);
    cyc("R10", 0, '0);
    cyc("R10", 1, mk(20, 1, 3, 15'h0001));
    cyc("R10", 0, '0);
    cyc("R8", 0, '0);
    for (int k = 0; k < 40; k++)
      cyc("R5", (k % 3) != 2, mk(k, (k % 5) == 0, k % 4, k * 977));
    cyc("R8", 0, '0);
    cyc("R8", 0, '0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule